// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a processor core and decides, every clock cycle, whether the core must enter an interrupt handler and at which address. It watches a set of interrupt sources. Each source has a pending request, an enable bit and a priority bit. From these it forms a one-cycle take pulse with a vector address, and it tracks which handler levels are currently running.

Two operating modes exist. A mode input, cleared after reset, selects compatibility operation. In that mode every source is treated as one level and vectors to address 0x000008. When the mode input is set, each source's priority bit sorts it into the high level (vector 0x000008) or the low level (vector 0x000018). A high-level request may then preempt a low-level handler that is already running.

Taking an interrupt masks further takes at that level until the core signals a return. The return strobe unwinds one nesting level, innermost first. Saving context and the core pipeline are outside this block.

Top module: `dual_level_irq_ctrl`

## Requirements
- R1: After a synchronous reset, take_o is 0, vec_o is 0, hi_act_o and lo_act_o are 0 and depth_o is 0.
- R2: With prio_mode_i = 0, a source that is both pending and enabled, together with glb_hi_i = 1 and no running high-level handler, causes a take with vec_o = 0x000008 and sets hi_act_o. In this mode src_hi_i and glb_lo_i have no effect.
- R3: With prio_mode_i = 1, a pending and enabled source whose priority bit is 1 (bit i of src_hi_i = 1 means high), together with glb_hi_i = 1 and hi_act_o = 0, causes a take with vec_o = 0x000008 and sets hi_act_o.
- R4: With prio_mode_i = 1, a pending and enabled source whose priority bit is 0 causes a take with vec_o = 0x000018 and sets lo_act_o. This happens only when glb_lo_i = 1, glb_hi_i = 1, and neither handler level is running.
- R5: When high and low requests are both eligible in the same cycle, the high request is taken (vector 0x000008).
- R6: In priority mode, a high request is taken while a low handler runs. Both hi_act_o and lo_act_o are then 1 and depth_o is 2.
- R7: While hi_act_o is 1, no take occurs at all. Neither a low request nor a second high request nests in a high handler.
- R8: A source whose enable bit is 0 never causes a take. No take occurs at a level whose global enable input is 0.
- R9: take_o never stays high for two consecutive cycles. vec_o changes only in a cycle in which take_o is 1.
- R10: A cycle with ret_i = 1 clears hi_act_o if it is set, otherwise clears lo_act_o. It has no effect when no handler runs. No take is decided in a cycle in which ret_i = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | N_SRC | Pending flag per source |
| src_en_i | input | N_SRC | Enable bit per source |
| src_hi_i | input | N_SRC | Priority bit per source, 1 = high level |
| prio_mode_i | input | 1 | 1 = two-level mode, 0 = single-level compatibility |
| glb_hi_i | input | 1 | Global enable for the high (or single) level |
| glb_lo_i | input | 1 | Global enable for the low level |
| ret_i | input | 1 | Return-from-handler strobe |
| take_o | output | 1 | One-cycle interrupt-take pulse |
| vec_o | output | VEC_W | Vector address of the latest take |
| hi_act_o | output | 1 | A high-level handler is running |
| lo_act_o | output | 1 | A low-level handler is running |
| depth_o | output | 2 | Number of nested running handlers |

## Verification
The assertions check, on every cycle, the properties that concern a single step of the block. The take pulse is one cycle wide, and the vector moves only with a take. A running high handler blocks every take, and a return cycle or the absence of any enabled request yields no take. Compatibility mode always vectors to 0x000008. Only the bench scenarios can show the rest: the choice of vector for particular request, enable and priority patterns, the arbitration when both levels are eligible together, the full preempt-then-unwind sequence with its depth values, and the low level's dependence on both global enables.

// File: rtl/irq2_pkg.sv
package irq2_pkg;

  // decision taken by the arbiter for one cycle
  typedef struct packed {
    logic go_hi;
    logic go_lo;
  } take_dec_t;

endpackage

// File: rtl/irq_src_sort.sv
module irq_src_sort #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [N_SRC-1:0] src_hi_i,
  output logic             any_o,
  output logic             hi_any_o,
  output logic             lo_any_o
);

  logic [N_SRC-1:0] live;
  logic [N_SRC-1:0] hi_live;
  logic [N_SRC-1:0] lo_live;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign live[i]    = src_req_i[i] & src_en_i[i];
    assign hi_live[i] = live[i] & src_hi_i[i];
    assign lo_live[i] = live[i] & ~src_hi_i[i];
  end

  assign any_o    = |live;
  assign hi_any_o = |hi_live;
  assign lo_any_o = |lo_live;

endmodule

// File: rtl/irq_take_arb.sv
module irq_take_arb
  import irq2_pkg::*;
(
  input  logic      any_i,
  input  logic      hi_any_i,
  input  logic      lo_any_i,
  input  logic      prio_mode_i,
  input  logic      glb_hi_i,
  input  logic      glb_lo_i,
  input  logic      hi_busy_i,
  input  logic      lo_busy_i,
  input  logic      take_q_i,
  input  logic      ret_i,
  output take_dec_t dec_o
);

  logic open_slot;
  logic hi_cand;

  // no decision while a pulse is out or while a return is being signalled
  assign open_slot = ~take_q_i & ~ret_i & glb_hi_i & ~hi_busy_i;
  // in compatibility mode every live source counts as high level
  assign hi_cand   = prio_mode_i ? hi_any_i : any_i;

  always_comb begin
    dec_o.go_hi = open_slot & hi_cand;
    dec_o.go_lo = open_slot & prio_mode_i & glb_lo_i & ~lo_busy_i
                  & lo_any_i & ~dec_o.go_hi;
  end

endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       push_hi_i,
  input  logic       push_lo_i,
  input  logic       ret_i,
  output logic       hi_busy_o,
  output logic       lo_busy_o,
  output logic [1:0] depth_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_busy_o <= 1'b0;
      lo_busy_o <= 1'b0;
    end else if (ret_i) begin
      if (hi_busy_o) hi_busy_o <= 1'b0;
      else           lo_busy_o <= 1'b0;
    end else begin
      if (push_hi_i) hi_busy_o <= 1'b1;
      if (push_lo_i) lo_busy_o <= 1'b1;
    end
  end

  assign depth_o = {1'b0, hi_busy_o} + {1'b0, lo_busy_o};

  // R10: a return pops the innermost level only
  a_r10_pop_inner: assert property (@(posedge clk) disable iff (rst)
    (ret_i && hi_busy_o) |=> (!hi_busy_o && lo_busy_o == $past(lo_busy_o)));

  // R10: return with nothing running leaves state empty
  a_r10_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !hi_busy_o && !lo_busy_o) |=> (!hi_busy_o && !lo_busy_o));

endmodule

// File: rtl/dual_level_irq_ctrl.sv
module dual_level_irq_ctrl
  import irq2_pkg::*;
#(
  parameter int               N_SRC  = 8,
  parameter int               VEC_W  = 21,
  parameter logic [VEC_W-1:0] HI_VEC = 21'h000008,
  parameter logic [VEC_W-1:0] LO_VEC = 21'h000018
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [N_SRC-1:0] src_hi_i,
  input  logic             prio_mode_i,
  input  logic             glb_hi_i,
  input  logic             glb_lo_i,
  input  logic             ret_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             hi_act_o,
  output logic             lo_act_o,
  output logic [1:0]       depth_o
);

  logic      any_w, hi_any_w, lo_any_w;
  logic      take_q;
  logic [VEC_W-1:0] vec_q;
  take_dec_t dec;

  irq_src_sort #(.N_SRC(N_SRC)) u_sort (
    .src_req_i (src_req_i),
    .src_en_i  (src_en_i),
    .src_hi_i  (src_hi_i),
    .any_o     (any_w),
    .hi_any_o  (hi_any_w),
    .lo_any_o  (lo_any_w)
  );

  irq_take_arb u_arb (
    .any_i       (any_w),
    .hi_any_i    (hi_any_w),
    .lo_any_i    (lo_any_w),
    .prio_mode_i (prio_mode_i),
    .glb_hi_i    (glb_hi_i),
    .glb_lo_i    (glb_lo_i),
    .hi_busy_i   (hi_act_o),
    .lo_busy_i   (lo_act_o),
    .take_q_i    (take_q),
    .ret_i       (ret_i),
    .dec_o       (dec)
  );

  irq_nest_track u_nest (
    .clk       (clk),
    .rst       (rst),
    .push_hi_i (dec.go_hi),
    .push_lo_i (dec.go_lo),
    .ret_i     (ret_i),
    .hi_busy_o (hi_act_o),
    .lo_busy_o (lo_act_o),
    .depth_o   (depth_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= dec.go_hi | dec.go_lo;
      if (dec.go_hi)      vec_q <= HI_VEC;
      else if (dec.go_lo) vec_q <= LO_VEC;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;

  // R1: reset leaves no pulse and no running handler
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!take_o && !hi_act_o && !lo_act_o && vec_o == '0));

  // R9: pulse is one cycle wide
  a_r9_take_single: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);

  // R9: vector moves only with a take
  a_r9_vec_stable: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> $stable(vec_o));

  // R7: a running high handler blocks every take
  a_r7_hi_blocks: assert property (@(posedge clk) disable iff (rst)
    (hi_act_o && !ret_i) |=> !take_o);

  // R2: compatibility mode always uses the high vector
  a_r2_compat_vec: assert property (@(posedge clk) disable iff (rst)
    (!prio_mode_i && !take_o) |=> (!take_o || vec_o == HI_VEC));

  // R8: nothing enabled and pending means no take
  a_r8_idle_no_take: assert property (@(posedge clk) disable iff (rst)
    !(|(src_req_i & src_en_i)) |=> !take_o);

  // R10: no take decided in a return cycle
  a_r10_ret_no_take: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> !take_o);

endmodule

// File: tb/sim_dual_level_irq_ctrl.sv
module sim_dual_level_irq_ctrl;

  localparam int N = 8;
  localparam logic [20:0] VH = 21'h000008;
  localparam logic [20:0] VL = 21'h000018;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0, en = '0, hi = '0;
  logic pm = 1'b0, gh = 1'b0, gl = 1'b0, ret = 1'b0;
  logic take;
  logic [20:0] vec;
  logic hact, lact;
  logic [1:0] dep;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dual_level_irq_ctrl #(.N_SRC(N)) u0 (
    .clk(clk), .rst(rst), .src_req_i(req), .src_en_i(en), .src_hi_i(hi),
    .prio_mode_i(pm), .glb_hi_i(gh), .glb_lo_i(gl), .ret_i(ret),
    .take_o(take), .vec_o(vec), .hi_act_o(hact), .lo_act_o(lact),
    .depth_o(dep)
  );

  // {pm, gh, gl, req, en, hi, exp_take, exp_vec_is_hi, exp_hact, exp_lact}
  localparam int NV = 11;
  localparam logic [30:0] TBL [NV] = '{
    {1'b0,1'b1,1'b0,8'h01,8'h01,8'h00,1'b1,1'b1,1'b1,1'b0}, // R2 prio bit ignored
    {1'b0,1'b1,1'b0,8'h80,8'h80,8'h00,1'b1,1'b1,1'b1,1'b0}, // R2 top source
    {1'b0,1'b0,1'b1,8'h01,8'h01,8'h00,1'b0,1'b0,1'b0,1'b0}, // R2 low enable ignored
    {1'b1,1'b1,1'b1,8'h04,8'h04,8'h04,1'b1,1'b1,1'b1,1'b0}, // R3
    {1'b1,1'b1,1'b1,8'h02,8'h02,8'h00,1'b1,1'b0,1'b0,1'b1}, // R4
    {1'b1,1'b1,1'b0,8'h02,8'h02,8'h00,1'b0,1'b0,1'b0,1'b0}, // R8 low global off
    {1'b1,1'b1,1'b1,8'h06,8'h06,8'h04,1'b1,1'b1,1'b1,1'b0}, // R5
    {1'b1,1'b1,1'b1,8'h0F,8'h00,8'h0F,1'b0,1'b0,1'b0,1'b0}, // R8 all disabled
    {1'b1,1'b0,1'b1,8'h02,8'h02,8'h00,1'b0,1'b0,1'b0,1'b0}, // R4 needs high enable
    {1'b1,1'b1,1'b1,8'h00,8'hFF,8'hFF,1'b0,1'b0,1'b0,1'b0}, // R8 nothing pending
    {1'b1,1'b1,1'b1,8'h10,8'h10,8'h10,1'b1,1'b1,1'b1,1'b0}  // R3 other source
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; en = '0; hi = '0; pm = 1'b0; gh = 1'b0; gl = 1'b0; ret = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 take", {31'd0, take}, 32'd0);
    chk("R1 vec", {11'd0, vec}, 32'd0);
    chk("R1 hact", {31'd0, hact}, 32'd0);
    chk("R1 lact", {31'd0, lact}, 32'd0);
    chk("R1 depth", {30'd0, dep}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [30:0] e;
      logic [20:0] ev;
      e = TBL[k];
      do_reset();
      pm = e[30]; gh = e[29]; gl = e[28];
      req = e[27:20]; en = e[19:12]; hi = e[11:4];
      step();
      ev = e[3] ? (e[2] ? VH : VL) : 21'd0;
      chk($sformatf("R2-R8 vector %0d take", k), {31'd0, take}, {31'd0, e[3]});
      chk($sformatf("R2-R8 vector %0d vec", k), {11'd0, vec}, {11'd0, ev});
      chk($sformatf("R2-R8 vector %0d act", k), {30'd0, hact, lact}, {30'd0, e[1], e[0]});
    end

    // R6: high preempts low handler
    do_reset();
    pm = 1; gh = 1; gl = 1; en = 8'hFF; hi = 8'hF0; req = 8'h01;
    step();
    chk("R4 low take", {11'd0, vec}, {11'd0, VL});
    req = 8'h10;
    step();
    chk("R9 gap after take", {31'd0, take}, 32'd0);
    step();
    chk("R6 preempt take", {31'd0, take}, 32'd1);
    chk("R6 preempt vec", {11'd0, vec}, {11'd0, VH});
    chk("R6 depth", {30'd0, dep}, 32'd2);
    // R7: nothing nests inside high
    req = 8'h31;
    step(); step();
    chk("R7 no nest in high", {31'd0, take}, 32'd0);
    chk("R7 depth kept", {30'd0, dep}, 32'd2);
    // R10: return pops high first and suppresses a take that cycle
    ret = 1;
    step();
    chk("R10 pop high", {30'd0, hact, lact}, 32'b01);
    chk("R10 no take on ret", {31'd0, take}, 32'd0);
    ret = 0;
    step();
    chk("R6 retake high over low", {31'd0, take}, 32'd1);
    req = 8'h00;
    ret = 1;
    step();
    chk("R10 pop again", {30'd0, hact, lact}, 32'b01);
    step();
    chk("R10 pop low", {30'd0, hact, lact}, 32'b00);
    step();
    chk("R10 empty pop", {30'd0, dep}, 32'd0);
    ret = 0;

    // R7: low never preempts high
    do_reset();
    pm = 1; gh = 1; gl = 1; en = 8'hFF; hi = 8'h80; req = 8'h80;
    step();
    chk("R3 high first", {30'd0, hact, lact}, 32'b10);
    req = 8'h01;
    step(); step();
    chk("R7 low blocked take", {31'd0, take}, 32'd0);
    chk("R7 low blocked act", {31'd0, lact}, 32'd0);

    // R9: held request in compatibility mode gives one pulse
    do_reset();
    gh = 1; en = 8'h01; req = 8'h01;
    step();
    chk("R9 first pulse", {31'd0, take}, 32'd1);
    step();
    chk("R9 pulse ends", {31'd0, take}, 32'd0);
    step(); step();
    chk("R9 no repeat", {31'd0, take}, 32'd0);
    chk("R9 vec held", {11'd0, vec}, {11'd0, VH});

    // R10: return cycle suppresses a pending take
    do_reset();
    pm = 1; gh = 1; en = 8'h04; hi = 8'h04; req = 8'h04; ret = 1;
    step();
    chk("R10 ret blocks take", {31'd0, take}, 32'd0);
    ret = 0;
    step();
    chk("R10 take after ret", {31'd0, take}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule